// File: doc/BRIEF.md
# Serial Clock Register Bank Receiver

This block is the receiving end of a two-wire programming link for a dual clock synthesizer. The two lines, a serial clock and a serial data line, first carry an unlock run and a start pattern. After that they carry a 24-bit word in which every bit arrives twice, first inverted and then true. When a valid stop follows, the word is written into one of six internal registers, picked by its three top bits. Those registers hold three video-clock settings, one memory-clock setting, a power-down divisor code and a small set of control bits. The block decodes the stored fields and presents them as plain numbers on its outputs. It does not model any oscillator.

In normal operation the same two lines, once synchronized, act as the video clock select pins. Together with a separate internal-clock strap input they pick which video register drives the output, or they route the external feature clock instead. The selected register's index field can also switch the video clock off or hand it the memory clock. A two-bit strap input chooses one of four sets of reset defaults. An active-low error flag reports a malformed bit pair or a malformed stop.

Top module: `clkprog_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads the reset defaults selected by c = `init_i`. For video registers d = 0, 1, 2 and for the memory register (d = 3), the Q field is 10c+d, the M field is d, the P field is 50+c and the index field is c+d. The power-down code is 8, which divides by 18. All control bits are cleared and `err_n_o` is high.
- R2: A frame starts only when DATA falls while CLK is low, after at least 6 CLK falling edges, each with DATA high, and with no DATA-low CLK fall or DATA fall in between. After fewer unlock pairs, the whole frame is ignored.
- R3: After the start pattern (two CLK rises with DATA low), each of the 24 bits is taken least significant first. The inverted value is sampled at the CLK fall and the true value at the next CLK rise. The stop is DATA high at both the next CLK fall and the next CLK rise, and the word is written only at that stop.
- R4: If the two samples of a bit are equal, `err_n_o` goes low, the word is discarded and no register changes. `err_n_o` stays low until the next accepted start pattern.
- R5: Word bits 23..21 pick the target register: 0, 1 and 2 are video registers 0 to 2, 3 is the memory register, 4 is the power-down register and 6 is the control register. Codes 5 and 7 write nothing.
- R6: In the video and memory registers, bits 6..0 hold Q, bits 9..7 hold M, bits 16..10 hold P and bits 20..17 hold the index. The `*_q_o` outputs give Q+2, the `*_p_o` outputs give P+3, the `*_div_o` outputs give 2^M and the `*_idx_o` outputs give the raw index.
- R7: With {sel1, sel0} = {synchronized DATA, synchronized CLK}: 00 picks video register 0, 01 picks register 1 and 11 picks register 2. 10 picks the feature clock when `intclk_i` is 0, and register 2 when `intclk_i` is 1. The video field outputs always show the picked register, which is register 2 for code 10. `vsrc_o` gives 0, 1 or 2 for the picked register and 4 for the feature clock.
- R8: If the feature clock is not picked, a picked register with index 14 gives `vsrc_o` = 5 (video clock off), and one with index 15 gives `vsrc_o` = 6 (memory clock routed to video).
- R9: A control write sets the prescale of video register n to 4 (instead of 2) from word bit 12+n, sets `chg_mclk_o` from bit 19 and sets `pd_mode2_o` from bit 20. `vid_pre_o` shows the prescale of the picked register.
- R10: A power-down write stores bits 20..17 as code k, and `pd_div_o` = 34 − 2k (1 gives 32, 15 gives 4).
- R11: A stop with DATA low at its CLK fall drives `err_n_o` low and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_clk_i | input | 1 | Serial clock line, also select bit 0 (asynchronous) |
| prog_dat_i | input | 1 | Serial data line, also select bit 1 (asynchronous) |
| intclk_i | input | 1 | Strap: 1 keeps select code 10 on register 2 (asynchronous) |
| init_i | input | 2 | Strap that picks the set of reset defaults |
| err_n_o | output | 1 | Low after a malformed bit pair or stop |
| vsrc_o | output | 3 | Video clock source code |
| vid_q_o | output | 8 | Picked video register, Q value |
| vid_div_o | output | 8 | Picked video register, post divide |
| vid_p_o | output | 8 | Picked video register, P value |
| vid_idx_o | output | 4 | Picked video register, range index |
| vid_pre_o | output | 3 | Picked video register, prescale (2 or 4) |
| mem_q_o | output | 8 | Memory register, Q value |
| mem_div_o | output | 8 | Memory register, post divide |
| mem_p_o | output | 8 | Memory register, P value |
| mem_idx_o | output | 4 | Memory register, range index |
| pd_div_o | output | 6 | Power-down divisor |
| chg_mclk_o | output | 1 | Source used during frequency changes: 1 memory clock |
| pd_mode2_o | output | 1 | 1 selects power-down mode 2 |

## Verification
A change on the select lines or `intclk_i` passes two synchronizer flops, so it reaches `vsrc_o` and the video fields two edges after the pins move. The last CLK rise of a stop is seen by the frame logic after two synchronizer flops. The frame logic registers the write pulse one edge later, and the register bank stores it one edge after that, so a write shows on the outputs four edges after the pin changes. A bad pair or stop pulls `err_n_o` low three edges after the offending CLK rise. The bench holds every line step for four cycles, waits eight cycles after each frame or select change, and samples on falling clock edges, well after each of these latencies.

// File: rtl/clkprog_pkg.sv
// Shared types and constants for the serial clock register bank receiver.
// Assumes a 24-bit command word whose top three bits name the target.
package clkprog_pkg;

    localparam int WORD_W     = 24;
    localparam int DEST_W     = 3;
    localparam int PAYLOAD_W  = WORD_W - DEST_W;
    localparam int UNLOCK_MIN = 6;
    localparam int NVID       = 3;
    localparam int PRE_LSB    = 12;
    localparam int CHG_BIT    = 19;
    localparam int PD2_BIT    = 20;

    localparam logic [DEST_W-1:0] DST_MEM = 3'd3;
    localparam logic [DEST_W-1:0] DST_PD  = 3'd4;
    localparam logic [DEST_W-1:0] DST_CTL = 3'd6;

    localparam logic [3:0] IDX_OFF  = 4'd14;
    localparam logic [3:0] IDX_MCLK = 4'd15;

    // Synthesizer setting as stored in the video and memory registers
    typedef struct packed {
        logic [3:0] idx;
        logic [6:0] p;
        logic [2:0] m;
        logic [6:0] q;
    } clkword_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_STOP
    } frame_st_t;

    typedef enum logic [2:0] {
        VS_REG0 = 3'd0,
        VS_REG1 = 3'd1,
        VS_REG2 = 3'd2,
        VS_FEAT = 3'd4,
        VS_OFF  = 3'd5,
        VS_MCLK = 3'd6
    } vsrc_t;

    // Reset default for register d (0..2 video, 3 memory) under strap code c
    function automatic clkword_t reset_word(input logic [1:0] c, input logic [1:0] d);
        clkword_t w;
        int unsigned ci;
        int unsigned di;
        ci    = int'(c);
        di    = int'(d);
        w.q   = 7'(10 * ci + di);
        w.m   = 3'(di);
        w.p   = 7'(50 + ci);
        w.idx = 4'(ci + di);
        return w;
    endfunction

endpackage

// File: rtl/clkprog_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
// Assumes inputs are quasi-static levels; resets all stages to zero.
module clkprog_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] ff [STAGES];

    // Shift each input through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) ff[i] <= '0;
        end else begin
            ff[0] <= d;
            for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
        end
    end

    assign q = ff[STAGES-1];

endmodule

// File: rtl/clkprog_frame.sv
// Frame decoder for the two-wire programming link.
// Counts unlock pairs, detects the start pattern, collects complementary
// bit pairs LSB first and emits a one-cycle write pulse at a valid stop.
// Assumes sclk/sdat are already synchronized to clk.
module clkprog_frame
    import clkprog_pkg::*;
#(
    parameter int FW         = WORD_W,
    parameter int UNLOCK_CNT = UNLOCK_MIN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          sdat,
    output logic          wr_valid,
    output logic [FW-1:0] wr_word,
    output logic          err_n
);

    localparam int CW  = $clog2(FW + 1);
    localparam int UCW = $clog2(UNLOCK_CNT + 1);
    localparam logic [CW-1:0]  LAST_BIT = CW'(FW - 1);
    localparam logic [UCW-1:0] UMAX     = UCW'(UNLOCK_CNT);

    frame_st_t       state;
    logic [UCW-1:0]  ucnt;
    logic [CW-1:0]   bitcnt;
    logic            inv_q;
    logic [FW-1:0]   shreg;
    logic            err_q;
    logic            sclk_q;
    logic            sdat_q;

    logic clk_rise, clk_fall, dat_rise, dat_fall;

    // Edge detection of the synchronized lines
    always_comb begin
        clk_rise = sclk & ~sclk_q;
        clk_fall = ~sclk & sclk_q;
        dat_rise = sdat & ~sdat_q;
        dat_fall = ~sdat & sdat_q;
    end

    // Frame sequencing: unlock, start, bit pairs, stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ucnt     <= '0;
            bitcnt   <= '0;
            inv_q    <= 1'b0;
            shreg    <= '0;
            err_q    <= 1'b0;
            wr_valid <= 1'b0;
            sclk_q   <= 1'b0;
            sdat_q   <= 1'b0;
        end else begin
            sclk_q   <= sclk;
            sdat_q   <= sdat;
            wr_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (clk_fall) begin
                        if (!sdat)             ucnt <= '0;
                        else if (ucnt != UMAX) ucnt <= ucnt + 1'b1;
                    end else if (dat_fall) begin
                        if (!sclk && ucnt == UMAX) begin
                            state  <= ST_START;
                            bitcnt <= '0;
                        end
                        ucnt <= '0;
                    end
                end
                ST_START: begin
                    if (dat_rise) begin
                        state <= ST_IDLE;
                    end else if (clk_rise) begin
                        if (sdat) begin
                            state <= ST_IDLE;
                        end else if (bitcnt == CW'(1)) begin
                            state  <= ST_BITS;
                            bitcnt <= '0;
                            err_q  <= 1'b0;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_BITS: begin
                    if (clk_fall) begin
                        inv_q <= sdat;
                    end else if (clk_rise) begin
                        if (sdat == inv_q) begin
                            err_q <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            shreg  <= {sdat, shreg[FW-1:1]};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == LAST_BIT) state <= ST_STOP;
                        end
                    end
                end
                ST_STOP: begin
                    if (clk_fall) begin
                        inv_q <= sdat;
                    end else if (clk_rise) begin
                        if (inv_q && sdat) wr_valid <= 1'b1;
                        else               err_q    <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign wr_word = shreg;
    assign err_n   = ~err_q;

    // Bit counter stays inside the word while collecting bits (R3)
    p_bitcnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BITS) |-> (bitcnt <= LAST_BIT));

    // A write pulse only follows the stop state (R3)
    p_write_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(state) == ST_STOP));

    // Error flag drops only while a word is in flight (R4, R11)
    p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |-> ($past(state) == ST_BITS || $past(state) == ST_STOP));

    // Error flag clears only at an accepted start (R4)
    p_err_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_n) |-> ($past(state) == ST_START));

endmodule

// File: rtl/clkprog_regs.sv
// Register bank: three video settings, memory setting, power-down code and
// control bits. Loads strap-selected defaults during reset and accepts a
// full word on each write pulse. Assumes wr_word is stable while wr_valid.
module clkprog_regs
    import clkprog_pkg::*;
#(
    parameter int NV = NVID
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             init_code,
    input  logic                   wr_valid,
    input  logic [WORD_W-1:0]      wr_word,
    output clkword_t [NV-1:0]      vid_words,
    output clkword_t               mem_word,
    output logic [3:0]             pd_code,
    output logic [NV-1:0]          pre4,
    output logic                   chg_mclk,
    output logic                   pd_mode2
);

    logic [DEST_W-1:0]    dest;
    logic [PAYLOAD_W-1:0] payload;

    assign dest    = wr_word[WORD_W-1 -: DEST_W];
    assign payload = wr_word[PAYLOAD_W-1:0];

    for (genvar g = 0; g < NV; g++) begin : g_vid
        localparam logic [DEST_W-1:0] MY_DEST = DEST_W'(g);
        // Video register g: default at reset, replaced on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)                          vid_words[g] <= reset_word(init_code, 2'(g));
            else if (wr_valid && dest == MY_DEST) vid_words[g] <= clkword_t'(payload);
        end
    end

    // Memory register
    always_ff @(posedge clk) begin
        if (!rst_n)                          mem_word <= reset_word(init_code, 2'd3);
        else if (wr_valid && dest == DST_MEM) mem_word <= clkword_t'(payload);
    end

    // Power-down divisor code
    always_ff @(posedge clk) begin
        if (!rst_n)                         pd_code <= 4'd8;
        else if (wr_valid && dest == DST_PD) pd_code <= payload[PAYLOAD_W-1 -: 4];
    end

    // Control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre4     <= '0;
            chg_mclk <= 1'b0;
            pd_mode2 <= 1'b0;
        end else if (wr_valid && dest == DST_CTL) begin
            pre4     <= wr_word[PRE_LSB +: NV];
            chg_mclk <= wr_word[CHG_BIT];
            pd_mode2 <= wr_word[PD2_BIT];
        end
    end

    // Unused target codes leave every register untouched (R5)
    p_bad_dest_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (dest == 3'd5 || dest == 3'd7)) |=>
        ($stable(vid_words) && $stable(mem_word) && $stable(pd_code) &&
         $stable(pre4) && $stable(chg_mclk) && $stable(pd_mode2)));

    // A power-down write stores the index-position field (R10)
    p_pd_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && dest == DST_PD) |=> (pd_code == $past(wr_word[20:17])));

endmodule

// File: rtl/clkprog_vsel.sv
// Video source selector: maps the select pins and the internal-clock strap
// to a register pick and a source code, applying the off / memory-clock
// index values. Purely combinational; assumes three video registers.
module clkprog_vsel
    import clkprog_pkg::*;
#(
    parameter int NV = NVID
) (
    input  logic [1:0]          sel,
    input  logic                intclk,
    input  logic [NV-1:0][3:0]  idx_all,
    output logic [1:0]          pick,
    output vsrc_t               vsrc
);

    logic       feat;
    logic [3:0] idx_pick;

    // Register pick: 00 and 01 direct, both 1x codes land on the last register
    always_comb begin
        unique case (sel)
            2'b00:   pick = 2'd0;
            2'b01:   pick = 2'd1;
            default: pick = 2'(NV - 1);
        endcase
        feat     = (sel == 2'b10) && !intclk;
        idx_pick = idx_all[pick];
    end

    // Source code: feature clock first, then the special index values
    always_comb begin
        if (feat)                       vsrc = VS_FEAT;
        else if (idx_pick == IDX_OFF)   vsrc = VS_OFF;
        else if (idx_pick == IDX_MCLK)  vsrc = VS_MCLK;
        else                            vsrc = vsrc_t'({1'b0, pick});
    end

endmodule

// File: rtl/clkprog_rx.sv
// Top of the serial clock register bank receiver. Synchronizes the link
// and strap pins, decodes frames, holds the register bank and presents the
// decoded fields of the picked video register and the memory register.
// Assumes init_i is static around reset.
module clkprog_rx
    import clkprog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_clk_i,
    input  logic       prog_dat_i,
    input  logic       intclk_i,
    input  logic [1:0] init_i,
    output logic       err_n_o,
    output logic [2:0] vsrc_o,
    output logic [7:0] vid_q_o,
    output logic [7:0] vid_div_o,
    output logic [7:0] vid_p_o,
    output logic [3:0] vid_idx_o,
    output logic [2:0] vid_pre_o,
    output logic [7:0] mem_q_o,
    output logic [7:0] mem_div_o,
    output logic [7:0] mem_p_o,
    output logic [3:0] mem_idx_o,
    output logic [5:0] pd_div_o,
    output logic       chg_mclk_o,
    output logic       pd_mode2_o
);

    logic [2:0]              sync_q;
    logic                    s_clk, s_dat, s_int;
    logic                    wr_valid;
    logic [WORD_W-1:0]       wr_word;
    clkword_t [NVID-1:0]     vid_words;
    clkword_t                mem_word;
    logic [3:0]              pd_code;
    logic [NVID-1:0]         pre4;
    logic [NVID-1:0][3:0]    idx_all;
    logic [1:0]              pick;
    vsrc_t                   vsrc;
    clkword_t                vw;

    clkprog_sync #(.W(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({intclk_i, prog_dat_i, prog_clk_i}),
        .q     (sync_q)
    );

    assign s_clk = sync_q[0];
    assign s_dat = sync_q[1];
    assign s_int = sync_q[2];

    clkprog_frame #(.FW(WORD_W), .UNLOCK_CNT(UNLOCK_MIN)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (s_clk),
        .sdat     (s_dat),
        .wr_valid (wr_valid),
        .wr_word  (wr_word),
        .err_n    (err_n_o)
    );

    clkprog_regs #(.NV(NVID)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_code (init_i),
        .wr_valid  (wr_valid),
        .wr_word   (wr_word),
        .vid_words (vid_words),
        .mem_word  (mem_word),
        .pd_code   (pd_code),
        .pre4      (pre4),
        .chg_mclk  (chg_mclk_o),
        .pd_mode2  (pd_mode2_o)
    );

    for (genvar g = 0; g < NVID; g++) begin : g_idx
        assign idx_all[g] = vid_words[g].idx;
    end

    clkprog_vsel #(.NV(NVID)) u_vsel (
        .sel     ({s_dat, s_clk}),
        .intclk  (s_int),
        .idx_all (idx_all),
        .pick    (pick),
        .vsrc    (vsrc)
    );

    // Field decode of the picked video register and the memory register
    always_comb begin
        vw        = vid_words[pick];
        vsrc_o    = vsrc;
        vid_q_o   = {1'b0, vw.q} + 8'd2;
        vid_p_o   = {1'b0, vw.p} + 8'd3;
        vid_div_o = 8'd1 << vw.m;
        vid_idx_o = vw.idx;
        vid_pre_o = pre4[pick] ? 3'd4 : 3'd2;
        mem_q_o   = {1'b0, mem_word.q} + 8'd2;
        mem_p_o   = {1'b0, mem_word.p} + 8'd3;
        mem_div_o = 8'd1 << mem_word.m;
        mem_idx_o = mem_word.idx;
        pd_div_o  = 6'd34 - {1'b0, pd_code, 1'b0};
    end

    // Source code is always one of the defined values (R7)
    p_src_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vsrc_o != 3'd3) && (vsrc_o != 3'd7));

    // Clock-off code only with index 14 on the picked register (R8)
    p_off_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vsrc_o == 3'd5) |-> (vid_idx_o == 4'd14));

endmodule

// File: tb/tb_clkprog_rx.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset defaults, register targets, framing errors and limits.
module tb_clkprog_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pclk = 1'b0;
    logic       pdat = 1'b0;
    logic       intclk = 1'b1;
    logic [1:0] init = 2'd1;
    logic       err_n;
    logic [2:0] vsrc;
    logic [7:0] vid_q, vid_div, vid_p, mem_q, mem_div, mem_p;
    logic [3:0] vid_idx, mem_idx;
    logic [2:0] vid_pre;
    logic [5:0] pd_div;
    logic       chg_mclk, pd_mode2;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    clkprog_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_clk_i (pclk),
        .prog_dat_i (pdat),
        .intclk_i   (intclk),
        .init_i     (init),
        .err_n_o    (err_n),
        .vsrc_o     (vsrc),
        .vid_q_o    (vid_q),
        .vid_div_o  (vid_div),
        .vid_p_o    (vid_p),
        .vid_idx_o  (vid_idx),
        .vid_pre_o  (vid_pre),
        .mem_q_o    (mem_q),
        .mem_div_o  (mem_div),
        .mem_p_o    (mem_p),
        .mem_idx_o  (mem_idx),
        .pd_div_o   (pd_div),
        .chg_mclk_o (chg_mclk),
        .pd_mode2_o (pd_mode2)
    );

    typedef struct packed {
        logic [23:0] w;
        logic [1:0]  sel;
        logic        ic;
        logic [2:0]  src;
        logic [7:0]  q;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{ {3'd0, 4'd5,  7'd20, 3'd2, 7'd11}, 2'b00, 1'b1, 3'd0, 8'd13 },
        '{ {3'd1, 4'd3,  7'd60, 3'd1, 7'd30}, 2'b01, 1'b1, 3'd1, 8'd32 },
        '{ {3'd2, 4'd14, 7'd5,  3'd0, 7'd0 }, 2'b11, 1'b1, 3'd5, 8'd2  },
        '{ {3'd2, 4'd15, 7'd5,  3'd0, 7'd7 }, 2'b11, 1'b0, 3'd6, 8'd9  },
        '{ {3'd2, 4'd15, 7'd5,  3'd0, 7'd7 }, 2'b10, 1'b0, 3'd4, 8'd9  },
        '{ {3'd2, 4'd15, 7'd5,  3'd0, 7'd7 }, 2'b10, 1'b1, 3'd6, 8'd9  },
        '{ {3'd2, 4'd4,  7'd5,  3'd0, 7'd7 }, 2'b10, 1'b1, 3'd2, 8'd9  }
    };

    localparam logic [23:0] W_ONES0 = {3'd0, 4'd15, 7'd127, 3'd7, 7'd127};
    localparam logic [23:0] W_ONES1 = {3'd1, 4'd15, 7'd127, 3'd7, 7'd127};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One line step: drive at a falling edge, hold four cycles
    task automatic lines(input logic c, input logic d);
        @(negedge clk);
        pclk = c;
        pdat = d;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_sel(input logic [1:0] s, input logic ic);
        intclk = ic;
        lines(s[0], s[1]);
        repeat (8) @(negedge clk);
    endtask

    // Full frame; bad_bit >= 0 corrupts that pair, bad_stop lowers DATA at stop fall
    task automatic send_frame(input logic [23:0] w, input int npairs,
                              input int bad_bit, input bit bad_stop);
        for (int i = 0; i < npairs; i++) begin
            lines(1'b1, 1'b1);
            lines(1'b0, 1'b1);
        end
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        lines(1'b0, 1'b0);
        lines(1'b1, 1'b0);
        for (int i = 0; i < 24; i++) begin
            logic d;
            logic t;
            d = w[i];
            t = (i == bad_bit) ? ~d : d;
            lines(1'b1, ~d);
            lines(1'b0, ~d);
            lines(1'b0, t);
            lines(1'b1, t);
        end
        lines(1'b1, 1'b1);
        lines(1'b0, bad_stop ? 1'b0 : 1'b1);
        lines(1'b1, 1'b1);
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1: reset defaults with strap code 1
        chk("R1 vid_q",   vid_q,   12);
        chk("R1 vid_p",   vid_p,   54);
        chk("R1 vid_div", vid_div, 1);
        chk("R1 vid_idx", vid_idx, 1);
        chk("R1 mem_q",   mem_q,   15);
        chk("R1 mem_div", mem_div, 8);
        chk("R1 mem_idx", mem_idx, 4);
        chk("R1 pd_div",  pd_div,  18);
        chk("R1 err_n",   err_n,   1);
        chk("R1 vid_pre", vid_pre, 2);
        chk("R1 vsrc",    vsrc,    0);

        // Vector table: write, select, check source and decoded Q (R3, R6, R7, R8)
        for (int i = 0; i < NVEC; i++) begin
            send_frame(VECS[i].w, 8, -1, 1'b0);
            set_sel(VECS[i].sel, VECS[i].ic);
            chk($sformatf("R7/R8 vec%0d vsrc", i), vsrc, VECS[i].src);
            chk($sformatf("R3/R6 vec%0d vid_q", i), vid_q, VECS[i].q);
        end

        // R5, R6: memory register fields
        send_frame({3'd3, 4'd9, 7'd100, 3'd4, 7'd50}, 8, -1, 1'b0);
        chk("R6 mem_q",   mem_q,   52);
        chk("R6 mem_p",   mem_p,   103);
        chk("R6 mem_div", mem_div, 16);
        chk("R5 mem_idx", mem_idx, 9);

        // R10: power-down divisor extremes
        send_frame({3'd4, 4'd15, 17'd0}, 8, -1, 1'b0);
        chk("R10 pd_div code15", pd_div, 4);
        send_frame({3'd4, 4'd1, 17'd0}, 8, -1, 1'b0);
        chk("R10 pd_div code1", pd_div, 32);

        // R9: control bits 12 and 19
        w = 24'd0; w[23:21] = 3'd6; w[12] = 1'b1; w[19] = 1'b1;
        send_frame(w, 8, -1, 1'b0);
        set_sel(2'b00, 1'b1);
        chk("R9 pre reg0", vid_pre, 4);
        chk("R9 chg_mclk", chg_mclk, 1);
        chk("R9 pd_mode2", pd_mode2, 0);
        set_sel(2'b01, 1'b1);
        chk("R9 pre reg1", vid_pre, 2);

        // R9: control bits 14 and 20
        w = 24'd0; w[23:21] = 3'd6; w[14] = 1'b1; w[20] = 1'b1;
        send_frame(w, 8, -1, 1'b0);
        set_sel(2'b11, 1'b1);
        chk("R9 pre reg2", vid_pre, 4);
        chk("R9 pd_mode2 set", pd_mode2, 1);
        chk("R9 chg_mclk clr", chg_mclk, 0);

        // R5: codes 5 and 7 write nothing
        send_frame({3'd5, 21'h1FFFFF}, 8, -1, 1'b0);
        send_frame({3'd7, 21'h1FFFFF}, 8, -1, 1'b0);
        chk("R5 mem_q held", mem_q, 52);
        chk("R5 pd held", pd_div, 32);
        chk("R5 ctrl held", chg_mclk, 0);
        chk("R5 pd_mode2 held", pd_mode2, 1);
        set_sel(2'b00, 1'b1);
        chk("R5 reg0 held", vid_q, 13);
        chk("R5 err_n", err_n, 1);

        // R2: five unlock pairs are not enough
        send_frame(W_ONES0, 5, -1, 1'b0);
        set_sel(2'b00, 1'b1);
        chk("R2 short unlock ignored", vid_q, 13);

        // R4: non-complementary pair
        send_frame(W_ONES0, 8, 3, 1'b0);
        set_sel(2'b00, 1'b1);
        chk("R4 err_n low", err_n, 0);
        chk("R4 word discarded", vid_q, 13);

        // R11: bad stop
        send_frame(W_ONES1, 8, -1, 1'b1);
        set_sel(2'b01, 1'b1);
        chk("R11 err_n low", err_n, 0);
        chk("R11 no write", vid_q, 32);

        // R2, R4, R8: exactly six unlock pairs, error clears, index 15 routes memory clock
        send_frame(W_ONES0, 6, -1, 1'b0);
        set_sel(2'b00, 1'b1);
        chk("R4 err_n cleared", err_n, 1);
        chk("R2 six pairs accepted", vid_q, 129);
        chk("R8 idx15 vsrc", vsrc, 6);

        // R1: second reset with strap code 2 after an error
        send_frame(W_ONES1, 8, 0, 1'b0);
        set_sel(2'b00, 1'b1);
        @(negedge clk);
        init  = 2'd2;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R1 reset2 vid_q",   vid_q,   22);
        chk("R1 reset2 vid_p",   vid_p,   55);
        chk("R1 reset2 vid_idx", vid_idx, 2);
        chk("R1 reset2 mem_q",   mem_q,   25);
        chk("R1 reset2 mem_idx", mem_idx, 5);
        chk("R1 reset2 pd_div",  pd_div,  18);
        chk("R1 reset2 err_n",   err_n,   1);
        chk("R1 reset2 pd_mode2", pd_mode2, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule